// File: doc/BRIEF.md
# Minute-Frame Amplitude Keyer

This block turns a 60-bit minute frame into a once-per-second keying of a carrier's amplitude. A one-millisecond enable tick (`tick_ms`) advances a millisecond counter, and the counter's wrap advances a second counter that runs through one minute. In each second except the last one of the minute, the block lowers the amplitude at the start of the second. The length of the dip depends on the frame bit for that second. Full amplitude then holds until the second ends. In the last second there is no dip at all, and that gap marks the minute.

The block drives two channels of an external tone generator with 2-bit scale codes. Each channel takes a different reduced depth during a dip. It also gives a carrier-free binary level whose polarity a configuration pin selects. Throughout the marker second it raises a frame request to the frame source. The tick that ends the marker second captures the offered frame, which then drives the whole next minute. The second counter can be loaded from outside so that it can be aligned to a real time.

The control is a three-state machine:
- `ST_DIP`: amplitude reduced.
- `ST_FULL`: full amplitude for the rest of a data second.
- `ST_MARK`: the marker second at full amplitude.

Transitions:
- DIP_DONE (`ST_DIP` to `ST_FULL`): taken on the tick that closes the dip.
- NEXT_DATA (`ST_FULL` to `ST_DIP`): taken at the end of a second when the following second carries data.
- NEXT_MARK (`ST_FULL` to `ST_MARK`): taken at the end of a second when the following second is the marker.
- MINUTE_START (`ST_MARK` to `ST_DIP`): taken at the end of the marker second.
- FORCE_LOAD (any state to `ST_DIP`, or to `ST_MARK` when the loaded second is the marker): taken on a load strobe.

Top module: `keyer_top`

## Requirements
- R1: After reset the block sits in the marker second. `sec_idx` is SECS_PER_MIN-1, both scale codes are 2'b00, `frame_req` is 1 and the latched frame is all zero.
- R2: Every TICKS_PER_SEC ticks of `tick_ms` make one second. `sec_idx` counts 0 up to SECS_PER_MIN-1 and then wraps to 0, changing on the clock edge that takes the last tick of a second.
- R3: In a data second s (s < SECS_PER_MIN-1) the dip starts with the second. It lasts SHORT_TICKS ticks when bit s of the latched frame is 0 and LONG_TICKS ticks when it is 1. Bit index s is the second number, with bit 0 sent in second 0.
- R4: After the dip, full amplitude holds for the remaining ticks of that second.
- R5: In second SECS_PER_MIN-1 there is no dip, and full amplitude holds for the whole second.
- R6: During a dip `ch1_scale` is 2'b10 (quarter amplitude) and `ch2_scale` is 2'b11 (eighth amplitude). At full amplitude both are 2'b00.
- R7: When `pol_inv` is 0, `bin_out` is 0 during a dip and 1 otherwise. When `pol_inv` is 1, both levels are reversed.
- R8: `frame_req` is 1 exactly while `sec_idx` is SECS_PER_MIN-1. `frame_in` is captured on the tick that ends that second.
- R9: The captured frame drives the whole following minute, whatever `frame_in` does meanwhile.
- R10: A `load_sec` strobe sets `sec_idx` to `load_val` and restarts the millisecond count at 0. It takes priority over a tick in the same cycle, and the dip for the loaded second, if any, starts at once from the latched frame.
- R11: In cycles with neither `tick_ms` nor `load_sec`, the second count and the outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle millisecond enable |
| pol_inv | input | 1 | Inverts the binary output level |
| load_sec | input | 1 | Strobe that loads the second counter |
| load_val | input | SEC_W (6) | Second number to load |
| frame_in | input | SECS_PER_MIN (60) | Frame offered by the source, bit s for second s |
| frame_req | output | 1 | Asks the source for the next frame |
| sec_idx | output | SEC_W (6) | Current second of the minute |
| ch1_scale | output | 2 | Scale code for tone channel 1 |
| ch2_scale | output | 2 | Scale code for tone channel 2 |
| bin_out | output | 1 | Carrier-free keying level |

## Verification
The assertions assume that `load_val` never exceeds SECS_PER_MIN-1. They also assume that the parameters keep SHORT_TICKS at 1 or more and LONG_TICKS below TICKS_PER_SEC, so every dip ends inside its own second. The bench only loads legal second numbers and uses a small configuration that keeps those parameter limits. It runs whole minutes tick by tick with pauses between ticks, changes the frame in mid-minute and issues a load together with a tick in the same cycle. At every step it compares the outputs with a model that works out the second and millisecond from the tick count.

// File: rtl/keyer_pkg.sv
package keyer_pkg;

    typedef enum logic [1:0] {
        ST_DIP  = 2'd0,
        ST_FULL = 2'd1,
        ST_MARK = 2'd2
    } key_state_t;

    localparam logic [1:0] SCALE_FULL    = 2'b00;
    localparam logic [1:0] SCALE_QUARTER = 2'b10;
    localparam logic [1:0] SCALE_EIGHTH  = 2'b11;

endpackage

// File: rtl/keyer_ms_timer.sv
module keyer_ms_timer #(
    parameter int TICKS = 1000,
    parameter int MS_W  = $clog2(TICKS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            restart,
    output logic [MS_W-1:0] ms_cnt,
    output logic            ms_last
);

    localparam logic [MS_W-1:0] LAST = MS_W'(TICKS - 1);

    assign ms_last = (ms_cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ms_cnt <= '0;
        end else if (restart) begin
            ms_cnt <= '0;
        end else if (tick) begin
            if (ms_last) begin
                ms_cnt <= '0;
            end else begin
                ms_cnt <= ms_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/keyer_sec_counter.sv
module keyer_sec_counter #(
    parameter int SECS  = 60,
    parameter int SEC_W = $clog2(SECS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             load,
    input  logic [SEC_W-1:0] load_val,
    output logic [SEC_W-1:0] sec,
    output logic             is_marker,
    output logic             next_marker,
    output logic             load_marker
);

    localparam logic [SEC_W-1:0] MARK     = SEC_W'(SECS - 1);
    localparam logic [SEC_W-1:0] PRE_MARK = SEC_W'(SECS - 2);

    assign is_marker   = (sec == MARK);
    assign next_marker = (sec == PRE_MARK);
    assign load_marker = (load_val == MARK);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec <= MARK;
        end else if (load) begin
            sec <= load_val;
        end else if (advance) begin
            if (is_marker) begin
                sec <= '0;
            end else begin
                sec <= sec + 1'b1;
            end
        end
    end

endmodule

// File: rtl/keyer_frame_store.sv
module keyer_frame_store #(
    parameter int W = 60
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic [W-1:0] frame_in,
    output logic [W-1:0] frame_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (capture) begin
            frame_q <= frame_in;
        end
    end

endmodule

// File: rtl/keyer_fsm.sv
module keyer_fsm
    import keyer_pkg::*;
#(
    parameter int MS_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            load,
    input  logic            load_marker,
    input  logic            ms_last,
    input  logic            next_marker,
    input  logic [MS_W-1:0] ms_cnt,
    input  logic [MS_W-1:0] dip_last_idx,
    input  logic            pol_inv,
    output key_state_t      state,
    output logic [1:0]      ch1_scale,
    output logic [1:0]      ch2_scale,
    output logic            bin_out
);

    key_state_t state_nxt;
    logic       dip_done;

    assign dip_done = tick && (ms_cnt == dip_last_idx);

    always_comb begin
        state_nxt = state;
        if (load) begin
            state_nxt = load_marker ? ST_MARK : ST_DIP;
        end else begin
            unique case (state)
                ST_DIP: begin
                    if (dip_done) begin
                        state_nxt = ST_FULL;
                    end
                end
                ST_FULL: begin
                    if (tick && ms_last) begin
                        state_nxt = next_marker ? ST_MARK : ST_DIP;
                    end
                end
                ST_MARK: begin
                    if (tick && ms_last) begin
                        state_nxt = ST_DIP;
                    end
                end
                default: state_nxt = ST_MARK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_MARK;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        unique case (state)
            ST_DIP: begin
                ch1_scale = SCALE_QUARTER;
                ch2_scale = SCALE_EIGHTH;
                bin_out   = pol_inv;
            end
            ST_FULL, ST_MARK: begin
                ch1_scale = SCALE_FULL;
                ch2_scale = SCALE_FULL;
                bin_out   = !pol_inv;
            end
            default: begin
                ch1_scale = SCALE_FULL;
                ch2_scale = SCALE_FULL;
                bin_out   = !pol_inv;
            end
        endcase
    end

endmodule

// File: rtl/keyer_top.sv
module keyer_top
    import keyer_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1000,
    parameter int SHORT_TICKS   = 100,
    parameter int LONG_TICKS    = 200,
    parameter int SECS_PER_MIN  = 60,
    parameter int SEC_W         = $clog2(SECS_PER_MIN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick_ms,
    input  logic                    pol_inv,
    input  logic                    load_sec,
    input  logic [SEC_W-1:0]        load_val,
    input  logic [SECS_PER_MIN-1:0] frame_in,
    output logic                    frame_req,
    output logic [SEC_W-1:0]        sec_idx,
    output logic [1:0]              ch1_scale,
    output logic [1:0]              ch2_scale,
    output logic                    bin_out
);

    localparam int MS_W = $clog2(TICKS_PER_SEC);
    localparam logic [MS_W-1:0] SHORT_LAST = MS_W'(SHORT_TICKS - 1);
    localparam logic [MS_W-1:0] LONG_LAST  = MS_W'(LONG_TICKS - 1);

    logic [MS_W-1:0]         ms_cnt;
    logic                    ms_last;
    logic                    sec_advance;
    logic                    is_marker;
    logic                    next_marker;
    logic                    load_marker;
    logic                    capture;
    logic [SECS_PER_MIN-1:0] frame_q;
    logic                    cur_bit;
    logic [MS_W-1:0]         dip_last_idx;
    key_state_t              state;

    assign sec_advance  = tick_ms && ms_last && !load_sec;
    assign capture      = sec_advance && is_marker;
    assign cur_bit      = frame_q[sec_idx];
    assign dip_last_idx = cur_bit ? LONG_LAST : SHORT_LAST;
    assign frame_req    = is_marker;

    keyer_ms_timer #(
        .TICKS (TICKS_PER_SEC),
        .MS_W  (MS_W)
    ) u_ms (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_ms),
        .restart (load_sec),
        .ms_cnt  (ms_cnt),
        .ms_last (ms_last)
    );

    keyer_sec_counter #(
        .SECS  (SECS_PER_MIN),
        .SEC_W (SEC_W)
    ) u_sec (
        .clk         (clk),
        .rst_n       (rst_n),
        .advance     (sec_advance),
        .load        (load_sec),
        .load_val    (load_val),
        .sec         (sec_idx),
        .is_marker   (is_marker),
        .next_marker (next_marker),
        .load_marker (load_marker)
    );

    keyer_frame_store #(
        .W (SECS_PER_MIN)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .frame_in (frame_in),
        .frame_q  (frame_q)
    );

    keyer_fsm #(
        .MS_W (MS_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick_ms),
        .load         (load_sec),
        .load_marker  (load_marker),
        .ms_last      (ms_last),
        .next_marker  (next_marker),
        .ms_cnt       (ms_cnt),
        .dip_last_idx (dip_last_idx),
        .pol_inv      (pol_inv),
        .state        (state),
        .ch1_scale    (ch1_scale),
        .ch2_scale    (ch2_scale),
        .bin_out      (bin_out)
    );

endmodule

// File: rtl/keyer_top_chk.sv
module keyer_top_chk #(
    parameter int MS_W       = 10,
    parameter int SEC_W      = 6,
    parameter int FRAME_W    = 60,
    parameter int LONG_TICKS = 200
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_ms,
    input logic               load_sec,
    input logic               pol_inv,
    input logic               frame_req,
    input logic [SEC_W-1:0]   sec_idx,
    input logic [1:0]         ch1_scale,
    input logic [1:0]         ch2_scale,
    input logic               bin_out,
    input logic [MS_W-1:0]    ms_cnt,
    input logic [FRAME_W-1:0] frame_q
);

    localparam logic [SEC_W-1:0] MARK = SEC_W'(FRAME_W - 1);

    // R2
    sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_idx <= MARK);

    // R3
    dip_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch1_scale != 2'b00) |-> (ms_cnt < MS_W'(LONG_TICKS)));

    // R5
    marker_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_idx == MARK) |-> (ch1_scale == 2'b00 && ch2_scale == 2'b00));

    // R6
    scale_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch1_scale == 2'b00 && ch2_scale == 2'b00) ||
        (ch1_scale == 2'b10 && ch2_scale == 2'b11));

    // R7
    bin_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bin_out == ((ch1_scale != 2'b00) ~^ pol_inv));

    // R8
    req_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_req == (sec_idx == MARK));

    // R9
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_idx != MARK || !tick_ms) |=> $stable(frame_q));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_ms && !load_sec) |=> ($stable(sec_idx) && $stable(ch1_scale)));

endmodule

bind keyer_top keyer_top_chk #(
    .MS_W       (MS_W),
    .SEC_W      (SEC_W),
    .FRAME_W    (SECS_PER_MIN),
    .LONG_TICKS (LONG_TICKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_ms   (tick_ms),
    .load_sec  (load_sec),
    .pol_inv   (pol_inv),
    .frame_req (frame_req),
    .sec_idx   (sec_idx),
    .ch1_scale (ch1_scale),
    .ch2_scale (ch2_scale),
    .bin_out   (bin_out),
    .ms_cnt    (ms_cnt),
    .frame_q   (frame_q)
);

// File: tb/test_keyer_top.sv
module test_keyer_top;

    localparam int P  = 10;
    localparam int S  = 1;
    localparam int L  = 2;
    localparam int N  = 60;
    localparam int SW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          tick_ms;
    logic          pol_inv;
    logic          load_sec;
    logic [SW-1:0] load_val;
    logic [N-1:0]  frame_in;
    logic          frame_req;
    logic [SW-1:0] sec_idx;
    logic [1:0]    ch1_scale;
    logic [1:0]    ch2_scale;
    logic          bin_out;

    int           total = 0;
    int           bad   = 0;
    int           n_tk  = 0;
    int           base  = N - 1;
    logic [N-1:0] exp_frame = '0;

    localparam logic [N-1:0] F1 = 60'h0F3_5A96_C3C1_2B7D;
    localparam logic [N-1:0] F2 = 60'hA5C_0F69_3E1D_84B2;
    localparam logic [N-1:0] F3 = 60'h6DB_24E9_9A5F_0C33;

    always #5 clk = ~clk;

    keyer_top #(
        .TICKS_PER_SEC (P),
        .SHORT_TICKS   (S),
        .LONG_TICKS    (L),
        .SECS_PER_MIN  (N)
    ) i_keyer_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_ms   (tick_ms),
        .pol_inv   (pol_inv),
        .load_sec  (load_sec),
        .load_val  (load_val),
        .frame_in  (frame_in),
        .frame_req (frame_req),
        .sec_idx   (sec_idx),
        .ch1_scale (ch1_scale),
        .ch2_scale (ch2_scale),
        .bin_out   (bin_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (sec=%0d t=%0t)",
                     req, act, exp, sec_idx, $time);
        end
    endtask

    function automatic int m_ms();
        return n_tk % P;
    endfunction

    function automatic int m_sec();
        return (base + n_tk / P) % N;
    endfunction

    task automatic check_all(input string sec_tag);
        int  ms  = m_ms();
        int  sc  = m_sec();
        int  wid = exp_frame[sc] ? L : S;
        bit  dip = (sc != N - 1) && (ms < wid);
        string amp_tag;
        if (sc == N - 1)               amp_tag = "R5";
        else if (frame_in != exp_frame) amp_tag = "R9";
        else if (dip)                  amp_tag = "R3";
        else                           amp_tag = "R4";
        chk(sec_tag, int'(sec_idx), sc);
        chk(amp_tag, int'(ch1_scale), dip ? 2 : 0);
        chk("R6", int'(ch2_scale), dip ? 3 : 0);
        chk("R7", int'(bin_out), (dip ^ !pol_inv) ? 1 : 0);
        chk("R8", int'(frame_req), (sc == N - 1) ? 1 : 0);
    endtask

    task automatic do_tick();
        if (m_ms() == P - 1 && m_sec() == N - 1) exp_frame = frame_in;
        @(negedge clk) tick_ms = 1'b1;
        @(negedge clk) tick_ms = 1'b0;
        n_tk++;
        check_all("R2");
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            check_all("R11");
        end
    endtask

    task automatic load_at(input int s, input bit with_tick);
        @(negedge clk);
        load_sec = 1'b1;
        load_val = SW'(s);
        tick_ms  = with_tick;
        @(negedge clk);
        load_sec = 1'b0;
        tick_ms  = 1'b0;
        base = s;
        n_tk = 0;
        check_all("R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        tick_ms  = 1'b0;
        pol_inv  = 1'b0;
        load_sec = 1'b0;
        load_val = '0;
        frame_in = F1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", int'(sec_idx), N - 1);
        chk("R1", int'(ch1_scale), 0);
        chk("R1", int'(ch2_scale), 0);
        chk("R1", int'(frame_req), 1);
        chk("R1", int'(bin_out), 1);

        // marker second after reset, then full minute with F1
        for (int t = 0; t < P + N * P; t++) begin
            do_tick();
            if (t == 300) frame_in = F2;   // R9: change mid-minute
            if (t % 47 == 0) idle(3);
        end

        // inverted polarity for the next minute (R7)
        pol_inv = 1'b1;
        for (int t = 0; t < N * P; t++) begin
            do_tick();
            if (t == 123) frame_in = F3;
            if (t % 61 == 0) idle(2);
        end

        // R10: load with a tick in the same cycle
        pol_inv = 1'b0;
        load_at(5, 1'b1);
        for (int t = 0; t < 4 * P; t++) do_tick();
        load_at(17, 1'b0);
        for (int t = 0; t < 3; t++) do_tick();
        // load into the marker, then let it wrap and capture
        frame_in = F1;
        load_at(N - 1, 1'b0);
        for (int t = 0; t < 3 * P; t++) do_tick();
        frame_in = F2;
        for (int t = 0; t < N * P; t++) do_tick();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule